// File: doc/BRIEF.md
# Smart Card Answer-to-Reset Character Receiver

This block sits on the reader side of a contact smart card's asynchronous I/O line during activation. It keeps the card's reset line low until it is told to start. It then raises reset and waits for the card's first leading edge, which must fall inside an allowed clock window. After that it samples each character at the middle of every bit period. The bit period (one elementary time unit, ETU) is a whole number of card clock cycles. The block's clock is the card clock.

The first character tells the receiver how the card encodes data. Under direct convention a high level means logic one and bits arrive least significant first. Under inverse convention a low level means logic one and bits arrive most significant first. The receiver learns the convention from that first character and keeps it until the next reset. Every character after it is turned into a byte and flagged for parity or framing faults. If the card stays silent for too long, reception stops with a waiting-time timeout. The result is a byte stream with a one-cycle valid strobe, plus convention and error flags.

Top module: `scard_atr_rx`

## Requirements
- R1: After reset `card_rst_o` is low and every output flag is low. A `start_i` pulse raises `card_rst_o` on the next clock, and it stays high until the next reset.
- R2: A first falling edge earlier than `MIN_FIRST` clocks after reset release, or no falling edge within `MAX_FIRST` clocks, sets the sticky `window_err_o`. After that, no byte is produced.
- R3: Bit k of a character (k=0 start, 1..8 data, 9 parity, 10 stop) is sampled `ETU_CLKS/2` clocks after its nominal start, counted from the detected leading edge. `ETU_CLKS` defaults to 372.
- R4: A first character whose levels decode to 0x3B under direct convention is delivered as byte 0x3B, with `conv_valid_o`=1 and `inverse_o`=0.
- R5: A first character whose levels decode to 0x3F under inverse convention is delivered as byte 0x3F, with `conv_valid_o`=1 and `inverse_o`=1.
- R6: Any other first character sets the sticky `conv_err_o` and produces no byte. No later character produces a byte.
- R7: Under direct convention, data bit j received (j=0 first) is byte bit j, and a high level is 1.
- R8: Under inverse convention, data bit j received is byte bit 7-j, and a low level is 1.
- R9: Parity is even over the 8 data bits and the parity bit, counted as logic values under the detected convention. A violation sets `parity_err_o` in the same cycle as `byte_valid_o`.
- R10: A low level at the stop position sets `frame_err_o` in the same cycle as `byte_valid_o`. The byte is still delivered.
- R11: If no leading edge follows the previous one within `WAIT_ETU` ETUs, the sticky `timeout_o` is set and reception halts. Later characters produce no byte.
- R12: Each received character gives exactly one `byte_valid_o` pulse of one cycle, and the convention, once learned, does not change until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock; one ETU is ETU_CLKS of these |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that releases the card reset |
| io_i | input | 1 | Card I/O line level (idle high) |
| card_rst_o | output | 1 | Reset line driven to the card |
| byte_o | output | 8 | Decoded byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o and per-character flags |
| parity_err_o | output | 1 | Parity fault on the delivered byte |
| frame_err_o | output | 1 | Low stop level on the delivered byte |
| conv_valid_o | output | 1 | Convention has been learned |
| inverse_o | output | 1 | 1 = inverse convention, 0 = direct |
| conv_err_o | output | 1 | First character matched neither convention |
| window_err_o | output | 1 | First edge outside the allowed window |
| timeout_o | output | 1 | Waiting time between leading edges exceeded |

## Verification
The hardest case to reach from the ports is a halt state: the timeout, a wrong first character, or an edge outside the first-edge window. The receiver must then ignore a well-formed character that arrives afterwards. The bench shrinks the ETU and the waiting limit through parameters so that the timeout occurs within a short run. It then drives a complete character after each halt. The scoreboard treats any strobe with no queued expectation as a failure. Inverse convention is covered by encoding bytes in the bench from the stated level and order rules, with some parity bits deliberately flipped.

// File: rtl/scard_rx_pkg.sv
package scard_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FIRST,
        ST_RX,
        ST_GAP,
        ST_HALT
    } rx_state_e;

    localparam logic [7:0] TS_DIRECT  = 8'h3B;
    localparam logic [7:0] TS_INVERSE = 8'h3F;

endpackage

// File: rtl/scard_char_decode.sv
module scard_char_decode #(
    parameter bit INVERSE = 1'b0
) (
    input  logic [8:0] raw_i,
    output logic [7:0] byte_o,
    output logic       parity_err_o
);
    logic [8:0] logic_bits;

    always_comb begin
        logic_bits = INVERSE ? ~raw_i : raw_i;
        for (int j = 0; j < 8; j++) begin
            byte_o[j] = INVERSE ? logic_bits[7-j] : logic_bits[j];
        end
        parity_err_o = ^logic_bits;
    end
endmodule

// File: rtl/scard_wait_timer.sv
module scard_wait_timer #(
    parameter int ETU_CLKS = 372,
    parameter int WAIT_ETU = 9600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    output logic expired_o
);
    localparam int DW = $clog2(ETU_CLKS);
    localparam int EW = $clog2(WAIT_ETU + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(ETU_CLKS - 1);
    localparam logic [EW-1:0] LIMIT    = EW'(WAIT_ETU);

    typedef struct packed {
        logic [DW-1:0] div;
        logic [EW-1:0] etu;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear_i) begin
            tmr_d.div = '0;
            tmr_d.etu = '0;
        end else if (run_i && tmr_q.etu != LIMIT) begin
            if (tmr_q.div == DIV_LAST) begin
                tmr_d.div = '0;
                tmr_d.etu = tmr_q.etu + 1'b1;
            end else begin
                tmr_d.div = tmr_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired_o = (tmr_q.etu == LIMIT);
endmodule

// File: rtl/scard_atr_rx.sv
module scard_atr_rx #(
    parameter int ETU_CLKS  = 372,
    parameter int MIN_FIRST = 400,
    parameter int MAX_FIRST = 40000,
    parameter int WAIT_ETU  = 9600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       io_i,
    output logic       card_rst_o,
    output logic [7:0] byte_o,
    output logic       byte_valid_o,
    output logic       parity_err_o,
    output logic       frame_err_o,
    output logic       conv_valid_o,
    output logic       inverse_o,
    output logic       conv_err_o,
    output logic       window_err_o,
    output logic       timeout_o
);
    import scard_rx_pkg::*;

    localparam int CW = $clog2(ETU_CLKS);
    localparam int FW = $clog2(MAX_FIRST + 1);
    localparam logic [CW-1:0] ETU_LAST  = CW'(ETU_CLKS - 1);
    localparam logic [CW-1:0] MID_POINT = CW'(ETU_CLKS / 2);
    localparam logic [FW-1:0] FIRST_LO  = FW'(MIN_FIRST);
    localparam logic [FW-1:0] FIRST_HI  = FW'(MAX_FIRST);
    localparam logic [3:0]    STOP_IDX  = 4'd10;

    typedef struct packed {
        rx_state_e     st;
        logic          card_rst;
        logic          io_prev;
        logic [CW-1:0] etu_cnt;
        logic [3:0]    bit_idx;
        logic [8:0]    raw;
        logic [FW-1:0] first_cnt;
        logic          conv_known;
        logic          inverse;
        logic [7:0]    data;
        logic          valid;
        logic          perr;
        logic          ferr;
        logic          win_err;
        logic          conv_err;
        logic          tmo;
    } rx_t;

    rx_t rx_d, rx_q;

    // decoders for both conventions, index 0 direct, 1 inverse
    logic [7:0] dec_byte [2];
    logic       dec_perr [2];

    for (genvar g = 0; g < 2; g++) begin : g_dec
        scard_char_decode #(.INVERSE(g == 1)) u_dec (
            .raw_i        (rx_q.raw),
            .byte_o       (dec_byte[g]),
            .parity_err_o (dec_perr[g])
        );
    end

    logic tmr_clear, tmr_run, tmr_expired;

    scard_wait_timer #(.ETU_CLKS(ETU_CLKS), .WAIT_ETU(WAIT_ETU)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .clear_i   (tmr_clear),
        .expired_o (tmr_expired)
    );

    logic fall;
    assign fall    = rx_q.io_prev & ~io_i;
    assign tmr_run = (rx_q.st == ST_RX) || (rx_q.st == ST_GAP);

    always_comb begin
        rx_d         = rx_q;
        rx_d.valid   = 1'b0;
        rx_d.perr    = 1'b0;
        rx_d.ferr    = 1'b0;
        rx_d.io_prev = io_i;
        tmr_clear    = 1'b0;

        unique case (rx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    rx_d.card_rst  = 1'b1;
                    rx_d.first_cnt = '0;
                    rx_d.st        = ST_WAIT_FIRST;
                end
            end
            ST_WAIT_FIRST: begin
                if (fall) begin
                    if (rx_q.first_cnt < FIRST_LO) begin
                        rx_d.win_err = 1'b1;
                        rx_d.st      = ST_HALT;
                    end else begin
                        rx_d.st      = ST_RX;
                        rx_d.etu_cnt = CW'(1);
                        rx_d.bit_idx = '0;
                        tmr_clear    = 1'b1;
                    end
                end else if (rx_q.first_cnt == FIRST_HI) begin
                    rx_d.win_err = 1'b1;
                    rx_d.st      = ST_HALT;
                end else begin
                    rx_d.first_cnt = rx_q.first_cnt + 1'b1;
                end
            end
            ST_RX: begin
                rx_d.etu_cnt = (rx_q.etu_cnt == ETU_LAST) ? '0 : rx_q.etu_cnt + 1'b1;
                if (rx_q.etu_cnt == MID_POINT) begin
                    rx_d.bit_idx = rx_q.bit_idx + 1'b1;
                    if (rx_q.bit_idx == '0) begin
                        if (io_i) rx_d.st = ST_GAP;   // start bit not low: drop it
                    end else if (rx_q.bit_idx != STOP_IDX) begin
                        rx_d.raw = {io_i, rx_q.raw[8:1]};
                    end else begin
                        rx_d.st = ST_GAP;
                        if (!rx_q.conv_known) begin
                            if (dec_byte[0] == TS_DIRECT) begin
                                rx_d.conv_known = 1'b1;
                                rx_d.inverse    = 1'b0;
                            end else if (dec_byte[1] == TS_INVERSE) begin
                                rx_d.conv_known = 1'b1;
                                rx_d.inverse    = 1'b1;
                            end else begin
                                rx_d.conv_err = 1'b1;
                                rx_d.st       = ST_HALT;
                            end
                        end
                        if (rx_d.st == ST_GAP) begin
                            rx_d.valid = 1'b1;
                            rx_d.data  = dec_byte[rx_d.inverse];
                            rx_d.perr  = dec_perr[rx_d.inverse];
                            rx_d.ferr  = ~io_i;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (fall) begin
                    rx_d.st      = ST_RX;
                    rx_d.etu_cnt = CW'(1);
                    rx_d.bit_idx = '0;
                    tmr_clear    = 1'b1;
                end
            end
            default: ;
        endcase

        if (tmr_run && tmr_expired && !tmr_clear) begin
            rx_d.tmo   = 1'b1;
            rx_d.st    = ST_HALT;
            rx_d.valid = 1'b0;
            rx_d.perr  = 1'b0;
            rx_d.ferr  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q         <= '0;
            rx_q.st      <= ST_IDLE;
            rx_q.io_prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign card_rst_o   = rx_q.card_rst;
    assign byte_o       = rx_q.data;
    assign byte_valid_o = rx_q.valid;
    assign parity_err_o = rx_q.perr;
    assign frame_err_o  = rx_q.ferr;
    assign conv_valid_o = rx_q.conv_known;
    assign inverse_o    = rx_q.inverse;
    assign conv_err_o   = rx_q.conv_err;
    assign window_err_o = rx_q.win_err;
    assign timeout_o    = rx_q.tmo;
endmodule

// File: rtl/scard_atr_rx_chk.sv
module scard_atr_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic card_rst_o,
    input logic byte_valid_o,
    input logic parity_err_o,
    input logic frame_err_o,
    input logic conv_valid_o,
    input logic inverse_o,
    input logic conv_err_o,
    input logic window_err_o,
    input logic timeout_o
);
    a_r1_rst_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_o) |-> $past(start_i));

    a_r1_rst_held: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_o |=> card_rst_o);

    a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);

    a_r12_conv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid_o |=> conv_valid_o && $stable(inverse_o));

    a_r9_perr_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err_o |-> byte_valid_o);

    a_r10_ferr_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> byte_valid_o);

    // R2, R6, R11: a halt stops the byte stream and the flag stays set
    a_r11_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o || window_err_o || conv_err_o) |=> !byte_valid_o);

    a_r11_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> timeout_o);

    a_r2_window_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        window_err_o |=> window_err_o && !conv_valid_o);

    a_r6_conv_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        conv_err_o |-> !conv_valid_o);
endmodule

bind scard_atr_rx scard_atr_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .card_rst_o   (card_rst_o),
    .byte_valid_o (byte_valid_o),
    .parity_err_o (parity_err_o),
    .frame_err_o  (frame_err_o),
    .conv_valid_o (conv_valid_o),
    .inverse_o    (inverse_o),
    .conv_err_o   (conv_err_o),
    .window_err_o (window_err_o),
    .timeout_o    (timeout_o)
);

// File: tb/test_scard_atr_rx.sv
module test_scard_atr_rx;
    localparam int ETU  = 16;
    localparam int MINF = 50;
    localparam int MAXF = 600;
    localparam int WAIT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       io_i = 1'b1;
    logic       card_rst_o;
    logic [7:0] byte_o;
    logic       byte_valid_o, parity_err_o, frame_err_o;
    logic       conv_valid_o, inverse_o, conv_err_o, window_err_o, timeout_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [9:0] expq [$];   // {byte, perr, ferr}

    always #10 clk = ~clk;

    scard_atr_rx #(.ETU_CLKS(ETU), .MIN_FIRST(MINF), .MAX_FIRST(MAXF), .WAIT_ETU(WAIT)) i_scard_atr_rx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .io_i(io_i),
        .card_rst_o(card_rst_o), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
        .parity_err_o(parity_err_o), .frame_err_o(frame_err_o),
        .conv_valid_o(conv_valid_o), .inverse_o(inverse_o), .conv_err_o(conv_err_o),
        .window_err_o(window_err_o), .timeout_o(timeout_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // line levels for a byte: R7 direct, R8 inverse, R9 even parity
    function automatic logic [8:0] levels(input logic [7:0] b, input bit inv, input bit flip);
        logic [8:0] l;
        logic par;
        par = (^b) ^ flip;
        for (int i = 0; i < 8; i++) l[i] = inv ? ~b[7-i] : b[i];
        l[8] = inv ? ~par : par;
        return l;
    endfunction

    task automatic send_raw(input logic [8:0] l, input logic stop_lvl);
        @(negedge clk) io_i = 1'b0;
        repeat (ETU) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            io_i = l[i];
            repeat (ETU) @(negedge clk);
        end
        io_i = stop_lvl;
        repeat (ETU) @(negedge clk);
        io_i = 1'b1;
        repeat (2 * ETU) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit inv, input bit flip, input logic stop_lvl);
        expq.push_back({b, flip, ~stop_lvl});
        send_raw(levels(b, inv, flip), stop_lvl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0; io_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic activate(input int delay);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(card_rst_o === 1'b1, "R1 reset released", card_rst_o, 1);
        repeat (delay) @(negedge clk);
    endtask

    task automatic queue_empty(input string req);
        check(expq.size() == 0, req, expq.size(), 0);
        expq.delete();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && byte_valid_o) begin
            if (expq.size() == 0) begin
                check(1'b0, "R12 unexpected byte", byte_o, 0);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                check(byte_o == e[9:2], "R7/R8 byte value", byte_o, e[9:2]);
                check(parity_err_o == e[1], "R9 parity flag", parity_err_o, e[1]);
                check(frame_err_o == e[0], "R10 frame flag", frame_err_o, e[0]);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check(card_rst_o === 1'b0, "R1 card reset low", card_rst_o, 0);
        check({byte_valid_o, conv_valid_o, conv_err_o, window_err_o, timeout_o} === 5'b0,
              "R1 flags low", {byte_valid_o, conv_valid_o, conv_err_o, window_err_o, timeout_o}, 0);

        // Direct run: R3, R4, R7, R9, R10, R11
        activate(100);
        send_byte(8'h3B, 1'b0, 1'b0, 1'b1);
        check(conv_valid_o && !inverse_o, "R4 direct detected", {conv_valid_o, inverse_o}, 2);
        send_byte(8'hA5, 1'b0, 1'b0, 1'b1);
        send_byte(8'h00, 1'b0, 1'b0, 1'b1);
        send_byte(8'hFF, 1'b0, 1'b0, 1'b1);
        send_byte(8'h4E, 1'b0, 1'b1, 1'b1);
        send_byte(8'h12, 1'b0, 1'b0, 1'b0);
        queue_empty("R12 direct bytes all seen");
        repeat (20 * ETU) @(negedge clk);
        check(timeout_o == 1'b0, "R11 no early timeout", timeout_o, 0);
        repeat (15 * ETU) @(negedge clk);
        check(timeout_o == 1'b1, "R11 timeout raised", timeout_o, 1);
        send_raw(levels(8'h77, 1'b0, 1'b0), 1'b1);
        check(timeout_o == 1'b1 && card_rst_o, "R11 halted after timeout", timeout_o, 1);

        // Inverse run: R5, R8, R9, R12
        do_reset();
        activate(200);
        send_byte(8'h3F, 1'b1, 1'b0, 1'b1);
        check(conv_valid_o && inverse_o, "R5 inverse detected", {conv_valid_o, inverse_o}, 3);
        send_byte(8'h3C, 1'b1, 1'b0, 1'b1);
        send_byte(8'h81, 1'b1, 1'b0, 1'b1);
        send_byte(8'h5A, 1'b1, 1'b1, 1'b1);
        check(inverse_o == 1'b1, "R12 convention kept", inverse_o, 1);
        queue_empty("R12 inverse bytes all seen");

        // Early first edge: R2
        do_reset();
        activate(10);
        send_raw(levels(8'h3B, 1'b0, 1'b0), 1'b1);
        check(window_err_o == 1'b1, "R2 early edge", window_err_o, 1);
        check(conv_valid_o == 1'b0, "R2 no convention", conv_valid_o, 0);

        // Silent card: R2
        do_reset();
        activate(400);
        check(window_err_o == 1'b0, "R2 still in window", window_err_o, 0);
        repeat (300) @(negedge clk);
        check(window_err_o == 1'b1, "R2 late edge", window_err_o, 1);
        send_raw(levels(8'h3B, 1'b0, 1'b0), 1'b1);
        check(conv_valid_o == 1'b0, "R2 ignored after window error", conv_valid_o, 0);

        // Wrong initial character: R6
        do_reset();
        activate(100);
        send_raw(levels(8'h55, 1'b0, 1'b0), 1'b1);
        check(conv_err_o == 1'b1, "R6 convention error", conv_err_o, 1);
        send_raw(levels(8'h3B, 1'b0, 1'b0), 1'b1);
        check(conv_valid_o == 1'b0, "R6 reception stopped", conv_valid_o, 0);
        queue_empty("R6 no byte delivered");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule